// File: doc/BRIEF.md
# Memory Address-Decoder Fault Tester

This block drives a small one-bit-wide RAM through its address, write-select, data-in and enable pins, and reads its data-out pin, to find addressing faults. An address line stuck at 0 or 1 makes two addresses reach the same cell. A test that writes one cell and reads that same cell back cannot see this, because every such write and read lands on the same physical cell. This tester instead checks that a write to one address leaves every other address unchanged.

The test has two passes. The first pass uses a background of 0. Every address is written with the background value. Then, for each aggressor address in ascending order, the tester writes the opposite value to the aggressor. It reads each other address in ascending order and expects the background value. It reads the aggressor itself and expects the opposite value. Finally it writes the background value back to the aggressor. The second pass repeats the whole sequence with a background of 1 and writes of 0. This second pass catches disturbances that only act in one direction.

The first mismatch stops the test and freezes the verdict. That verdict names the address that was written (the aggressor) and the address whose read was wrong (the victim).

Top module: `addr_alias_tester`

## Requirements
- R1: A synchronous reset, whether in idle or in the middle of a test, forces done, pass, fail, the enable pin and both reported addresses to 0 on the next clock edge.
- R2: The tester leaves the enable pin low until it sees start high in idle. While a test is running, start has no effect: the run finishes in its normal number of cycles.
- R3: Each access holds address, write-select and data-in for one setup cycle with enable low. Enable is then high for exactly one cycle, with those three pins unchanged.
- R4: For a read, data-out is sampled in the cycle after the enable cycle. The address is still held and enable is low in that cycle. A read access takes 3 cycles and a write access takes 2.
- R5: The accesses follow the order given above, first with background 0 and then with background 1. This is 28 accesses per pass for 4 addresses.
- R6: On a fault-free RAM the tester sets done=1, pass=1, fail=0. Done rises 2·(2N + N·(3N+4)) cycles after the start edge (144 for N=4). The verdict holds until the next start or reset.
- R7: On the first read whose data differs from the expected value, the tester sets done=1, fail=1, pass=0, and never raises enable again until restarted.
- R8: With address line 0 stuck at either level, the tester reports aggressor 0 and victim 1. With address line 1 stuck at either level, it reports aggressor 0 and victim 2.
- R9: If an aggressor reads back wrong, the victim reported is the aggressor itself (for example, cell 2 stuck at 0 gives aggressor 2, victim 2).
- R10: If writing 0 to address 1 also clears address 3, while writing 1 has no such effect, the first pass completes and the second pass reports aggressor 1, victim 3.
- R11: A start in idle after a finished run clears done, pass and fail on the start edge and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a test when the tester is idle |
| ramAddr | output | ADDR_W | Address to the RAM under test |
| ramWrite | output | 1 | 1 selects write, 0 selects read |
| ramDin | output | 1 | Data bit written to the RAM |
| ramEn | output | 1 | RAM enable, a one-cycle pulse per access |
| ramDout | input | 1 | Data bit read from the RAM |
| done | output | 1 | Test finished, either way |
| pass | output | 1 | Test finished with no mismatch |
| fail | output | 1 | Test stopped on a mismatch |
| badAggressor | output | ADDR_W | Address written before the failing read |
| badVictim | output | ADDR_W | Address whose read mismatched |

## Verification
A wrong sequencer state shows on the RAM pins at once, as an access out of order, a second enable cycle, or a pin that moves during setup. The access-order scoreboard catches this at the very enable pulse where it happens. A wrong expected value or a wrong sampling cycle produces a false fail on a fault-free RAM, within the first aggressor step of the affected pass. A lost or miscounted address index shows up in one of two ways: the done edge arrives at a cycle other than 144, or a fault is reported with the wrong aggressor or victim pair.

// File: rtl/addr_alias_pkg.sv
package addr_alias_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_AGGW,
    ST_VREAD,
    ST_SELF,
    ST_RESTORE
  } seq_state_e;

  // Strobes from sequencer to result datapath
  typedef struct packed {
    logic clearRes;
    logic compare;
    logic expBit;
    logic finish;
  } dp_strobe_t;

endpackage

// File: rtl/addr_alias_ctrl.sv
module addr_alias_ctrl
  import addr_alias_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mismatch,
  output logic [ADDR_W-1:0] accAddr,
  output logic              accWrite,
  output logic              accData,
  output logic              accEn,
  output logic [ADDR_W-1:0] aggIdx,
  output dp_strobe_t        strobe
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [ADDR_W:0]   ONE_W = (ADDR_W+1)'(1);
  localparam logic [1:0] PH_EN = 2'd1;
  localparam logic [1:0] PH_SAMPLE = 2'd2;

  seq_state_e        state;
  logic [1:0]        ph;
  logic              bg;
  logic [ADDR_W-1:0] agg;
  logic [ADDR_W-1:0] idx;

  logic              isRead;
  logic              accEnd;
  logic [ADDR_W:0]   step1;
  logic [ADDR_W:0]   stepSkip;
  logic              vicDone;
  logic [ADDR_W-1:0] firstVic;

  assign aggIdx = agg;

  always_comb begin
    isRead   = (state == ST_VREAD) || (state == ST_SELF);
    accEnd   = (state != ST_IDLE) && (ph == (isRead ? PH_SAMPLE : PH_EN));
    accEn    = (state != ST_IDLE) && (ph == PH_EN);
    step1    = {1'b0, idx} + ONE_W;
    stepSkip = (step1 == {1'b0, agg}) ? step1 + ONE_W : step1;
    vicDone  = stepSkip[ADDR_W];
    firstVic = (agg == '0) ? ONE_A : '0;

    accAddr  = '0;
    accWrite = 1'b0;
    accData  = 1'b0;
    unique case (state)
      ST_FILL:    begin accAddr = idx; accWrite = 1'b1; accData = bg;  end
      ST_AGGW:    begin accAddr = agg; accWrite = 1'b1; accData = ~bg; end
      ST_VREAD:   begin accAddr = idx; end
      ST_SELF:    begin accAddr = agg; end
      ST_RESTORE: begin accAddr = agg; accWrite = 1'b1; accData = bg;  end
      default:    begin accAddr = '0; end
    endcase

    strobe.clearRes = (state == ST_IDLE) && start;
    strobe.compare  = isRead && (ph == PH_SAMPLE);
    strobe.expBit   = (state == ST_SELF) ? ~bg : bg;
    strobe.finish   = (state == ST_RESTORE) && accEnd && (agg == LAST_ADDR) && bg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ph    <= '0;
      bg    <= 1'b0;
      agg   <= '0;
      idx   <= '0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        state <= ST_FILL;
        ph    <= '0;
        bg    <= 1'b0;
        agg   <= '0;
        idx   <= '0;
      end
    end else if (strobe.compare && mismatch) begin
      state <= ST_IDLE;
      ph    <= '0;
    end else if (!accEnd) begin
      ph <= ph + 2'd1;
    end else begin
      ph <= '0;
      unique case (state)
        ST_FILL: begin
          if (idx == LAST_ADDR) begin
            state <= ST_AGGW;
            agg   <= '0;
          end else begin
            idx <= idx + ONE_A;
          end
        end
        ST_AGGW: begin
          state <= ST_VREAD;
          idx   <= firstVic;
        end
        ST_VREAD: begin
          if (vicDone) begin
            state <= ST_SELF;
          end else begin
            idx <= stepSkip[ADDR_W-1:0];
          end
        end
        ST_SELF: begin
          state <= ST_RESTORE;
        end
        ST_RESTORE: begin
          if (agg != LAST_ADDR) begin
            agg   <= agg + ONE_A;
            state <= ST_AGGW;
          end else if (!bg) begin
            bg    <= 1'b1;
            idx   <= '0;
            state <= ST_FILL;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/addr_alias_dp.sv
module addr_alias_dp
  import addr_alias_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_strobe_t        strobe,
  input  logic              ramDout,
  input  logic [ADDR_W-1:0] aggIdx,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              mismatch,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] badAggressor,
  output logic [ADDR_W-1:0] badVictim
);

  assign mismatch = strobe.compare && (ramDout != strobe.expBit);

  always_ff @(posedge clk) begin
    if (rst || strobe.clearRes) begin
      done         <= 1'b0;
      pass         <= 1'b0;
      fail         <= 1'b0;
      badAggressor <= '0;
      badVictim    <= '0;
    end else if (mismatch) begin
      done         <= 1'b1;
      fail         <= 1'b1;
      badAggressor <= aggIdx;
      badVictim    <= accAddr;
    end else if (strobe.finish) begin
      done <= 1'b1;
      pass <= 1'b1;
    end
  end

endmodule

// File: rtl/addr_alias_tester.sv
module addr_alias_tester
  import addr_alias_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWrite,
  output logic              ramDin,
  output logic              ramEn,
  input  logic              ramDout,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] badAggressor,
  output logic [ADDR_W-1:0] badVictim
);

  dp_strobe_t        strobe;
  logic              mismatch;
  logic [ADDR_W-1:0] aggIdx;

  addr_alias_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mismatch (mismatch),
    .accAddr  (ramAddr),
    .accWrite (ramWrite),
    .accData  (ramDin),
    .accEn    (ramEn),
    .aggIdx   (aggIdx),
    .strobe   (strobe)
  );

  addr_alias_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .ramDout      (ramDout),
    .aggIdx       (aggIdx),
    .accAddr      (ramAddr),
    .mismatch     (mismatch),
    .done         (done),
    .pass         (pass),
    .fail         (fail),
    .badAggressor (badAggressor),
    .badVictim    (badVictim)
  );

endmodule

// File: rtl/addr_alias_tester_chk.sv
module addr_alias_tester_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              ramWrite,
  input logic              ramDin,
  input logic              ramEn,
  input logic              done,
  input logic              pass,
  input logic              fail
);

  p_en_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    ramEn |=> !ramEn);

  p_setup_stable_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ramEn) |-> ($stable(ramAddr) && $stable(ramWrite) && $stable(ramDin)));

  p_read_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ramEn && !ramWrite) |=> ($stable(ramAddr) && !ramWrite && !ramEn));

  p_verdict_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass != fail));

  p_quiet_when_done_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !ramEn);

  p_flags_need_done_r6: assert property (@(posedge clk) disable iff (rst)
    (pass || fail) |-> done);

endmodule

bind addr_alias_tester addr_alias_tester_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ramAddr  (ramAddr),
  .ramWrite (ramWrite),
  .ramDin   (ramDin),
  .ramEn    (ramEn),
  .done     (done),
  .pass     (pass),
  .fail     (fail)
);

// File: tb/sim_addr_alias_tester.sv
module sim_addr_alias_tester;

  localparam int AW = 2;
  localparam int N = 1 << AW;
  localparam int FULL_CYCLES = 2 * (2*N + N*(3*N + 4));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] ramAddr;
  logic ramWrite, ramDin, ramEn;
  logic ramDout = 1'b0;
  logic done, pass, fail;
  logic [AW-1:0] badAggressor, badVictim;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  addr_alias_tester #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .ramAddr(ramAddr), .ramWrite(ramWrite), .ramDin(ramDin), .ramEn(ramEn),
    .ramDout(ramDout), .done(done), .pass(pass), .fail(fail),
    .badAggressor(badAggressor), .badVictim(badVictim)
  );

  // Behavioural RAM with fault injection
  logic memCells [N];
  int  stuckLine = -1;
  bit  stuckLineVal = 1'b0;
  int  stuckCell = -1;
  bit  stuckCellVal = 1'b0;
  int  coupleSrc = -1;
  int  coupleDst = -1;

  function automatic int effAddr(input logic [AW-1:0] a);
    logic [AW-1:0] e;
    e = a;
    if (stuckLine >= 0) e[stuckLine] = stuckLineVal;
    return int'(e);
  endfunction

  always @(posedge clk) begin
    if (ramEn && ramWrite) begin
      memCells[effAddr(ramAddr)] <= ramDin;
      if (!ramDin && effAddr(ramAddr) == coupleSrc) memCells[coupleDst] <= 1'b0;
    end
    // data-out is valid only in the cycle after a read enable
    if (ramEn && !ramWrite) begin
      if (effAddr(ramAddr) == stuckCell) ramDout <= stuckCellVal;
      else ramDout <= memCells[effAddr(ramAddr)];
    end else begin
      ramDout <= ~ramDout;
    end
  end

  // Scoreboard
  typedef struct { int addr; bit wr; bit data; } acc_t;
  acc_t expQ[$];
  bit monOn = 1'b0;
  int enCount = 0;
  logic [AW-1:0] prevAddr = '0;
  logic prevWrite = 1'b0, prevDin = 1'b0, prevEn = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pushExpected();
    expQ.delete();
    for (int b = 0; b < 2; b++) begin
      for (int a = 0; a < N; a++) expQ.push_back('{a, 1'b1, bit'(b)});
      for (int g = 0; g < N; g++) begin
        expQ.push_back('{g, 1'b1, bit'(1 - b)});
        for (int v = 0; v < N; v++) if (v != g) expQ.push_back('{v, 1'b0, 1'b0});
        expQ.push_back('{g, 1'b0, 1'b0});
        expQ.push_back('{g, 1'b1, bit'(b)});
      end
    end
  endtask

  always @(negedge clk) begin
    if (ramEn) enCount++;
    if (monOn && ramEn) begin
      if (!prevEn)
        check(prevAddr == ramAddr && prevWrite == ramWrite && prevDin == ramDin,
              "R3", "setup pins changed at enable", int'(ramAddr), int'(prevAddr));
      else
        check(1'b0, "R3", "enable high two cycles", 1, 0);
      if (expQ.size() == 0) begin
        check(1'b0, "R5", "unexpected access", int'(ramAddr), -1);
      end else begin
        acc_t e;
        e = expQ.pop_front();
        check(int'(ramAddr) == e.addr && ramWrite == e.wr && (!e.wr || ramDin == e.data),
              "R5", "access order addr/wr/din",
              int'({ramAddr, ramWrite, ramDin}), (e.addr << 2) | (int'(e.wr) << 1) | int'(e.data));
      end
    end
    prevAddr  = ramAddr;
    prevWrite = ramWrite;
    prevDin   = ramDin;
    prevEn    = ramEn;
  end

  task automatic clearFaults();
    stuckLine = -1; stuckCell = -1; coupleSrc = -1; coupleDst = -1;
    for (int i = 0; i < N; i++) memCells[i] = bit'(i % 2);
  endtask

  task automatic runTest(input bit midStart, output int n);
    pushExpected();
    monOn = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 1000) begin
      @(negedge clk);
      n++;
      if (midStart && n == 20) start = 1'b1;
      if (n == 21) start = 1'b0;
    end
    monOn = 1'b0;
  endtask

  task automatic expectFault(input string req, input int eAgg, input int eVic);
    int n;
    runTest(1'b0, n);
    check(done && fail && !pass, req, "fail verdict {done,fail,pass}",
          int'({done, fail, pass}), 6);
    check(int'(badAggressor) == eAgg, req, "aggressor", int'(badAggressor), eAgg);
    check(int'(badVictim) == eVic, req, "victim", int'(badVictim), eVic);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int e0;
    clearFaults();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !pass && !fail && !ramEn && badAggressor == '0 && badVictim == '0,
          "R1", "reset outputs", int'({done, pass, fail, ramEn}), 0);
    rst = 1'b0;
    // R2: no activity without start
    e0 = enCount;
    repeat (6) @(negedge clk);
    check(enCount == e0 && !done, "R2", "enables while idle", enCount - e0, 0);

    // R6, R5, R4 (fault-free RAM, data-out valid only one cycle)
    runTest(1'b0, n);
    check(n == FULL_CYCLES, "R6", "cycles to done", n, FULL_CYCLES);
    check(pass && !fail && done, "R6", "pass verdict {done,pass,fail}", int'({done, pass, fail}), 6);
    check(expQ.size() == 0, "R5", "accesses left over", expQ.size(), 0);

    // R2: start during a run ignored
    runTest(1'b1, n);
    check(n == FULL_CYCLES, "R2", "cycles with mid-run start", n, FULL_CYCLES);
    check(pass && !fail, "R2", "pass with mid-run start", int'({pass, fail}), 2);

    // R8: stuck address lines
    for (int line = 0; line < 2; line++) begin
      for (int v = 0; v < 2; v++) begin
        clearFaults();
        stuckLine = line;
        stuckLineVal = bit'(v);
        expectFault("R8", 0, (line == 0) ? 1 : 2);
      end
    end

    // R9: stuck cell, aggressor reads back wrong
    clearFaults();
    stuckCell = 2; stuckCellVal = 1'b0;
    expectFault("R9", 2, 2);

    // R10: one-directional coupling caught by the second pass
    clearFaults();
    coupleSrc = 1; coupleDst = 3;
    pushExpected();
    runTest(1'b0, n);
    check(n > FULL_CYCLES / 2, "R10", "failed after first pass (cycles)", n, FULL_CYCLES / 2 + 1);
    check(fail && !pass && int'(badAggressor) == 1 && int'(badVictim) == 3, "R10",
          "coupling agg/vic", int'({badAggressor, badVictim}), 7);

    // R7, R11: halt and hold after fail
    e0 = enCount;
    repeat (20) @(negedge clk);
    check(enCount == e0, "R7", "enables after fail", enCount - e0, 0);
    check(done && fail && int'(badAggressor) == 1 && int'(badVictim) == 3, "R11",
          "verdict held", int'({done, fail}), 3);

    // R11: restart clears flags
    clearFaults();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done && !pass && !fail, "R11", "flags after restart", int'({done, pass, fail}), 0);
    n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
    check(pass && !fail, "R11", "restart run verdict", int'({pass, fail}), 2);

    // R1: reset during a run
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!done && !pass && !fail && !ramEn, "R1", "mid-run reset", int'({done, pass, fail, ramEn}), 0);
    rst = 1'b0;
    e0 = enCount;
    repeat (5) @(negedge clk);
    check(enCount == e0, "R1", "idle after reset", enCount - e0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule